// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block is a bank of general-purpose pins, `PIN_COUNT` wide (up to 32), controlled over a small register bus. Software uses the bus to set each pin's output value, its direction, a blink enable and an input polarity inverter. Each input passes through a synchronizer and is then XORed with its polarity bit. The bus reads back this corrected value, and the interrupt logic uses it.

A 0-to-1 transition of a corrected input sets a sticky edge-cause bit. Software clears cause bits by writing 0 to them. Two per-pin masks select the interrupt sources. The edge mask gates the cause bits. The level mask gates the live corrected level. All enabled sources are ORed together into one registered interrupt request.

The two mask registers can be moved by a parameter, `MASK_SHIFT`, so that the bank fits an existing address layout. The other registers do not move with it. Outputs set to blink toggle from a shared free-running counter instead of showing their latch value.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every direction bit reads 1 (input), so `pin_oe` is all 0. The output, blink, polarity, cause, edge-mask and level-mask registers all read 0, and `irq` is 0.
- R2: The registers sit at these byte addresses. Output latch: 0x00. Direction: 0x04. Blink enable: 0x08. Polarity: 0x0C. Data in: 0x10, read-only. Edge cause: 0x14. Edge mask: 0x18 + `MASK_SHIFT`. Level mask: 0x1C + `MASK_SHIFT`. Each writable register reads back the value last written to it.
- R3: Direction bit 1 makes a pin an input, and direction bit 0 makes it an output. `pin_oe[i]` is the inverse of direction bit i. On a non-blinking pin, `pin_out[i]` equals output-latch bit i.
- R4: A read of data-in returns the synchronized pin value XORed with the polarity bit. A pin change is visible there two clock edges after it is sampled.
- R5: A cause bit sets when its corrected input goes from 0 to 1. With polarity 0 this is a rising pin edge. With polarity 1 it is a falling pin edge.
- R6: A write to the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R7: If a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R8: `irq` is a register. Its next value is the OR over all pins of (data-in AND level mask) OR (cause AND edge mask). It stays high for as long as any enabled source stays active.
- R9: A pin with blink enable 1 drives the top bit of a `BLINK_W`-bit free-running counter. It toggles every 2^(BLINK_W-1) cycles, whatever its latch bit holds.
- R10: A read request gives `bus_rvalid` with `bus_rdata` on the following cycle. A write gives no `bus_rvalid`. A write to data-in changes nothing.
- R11: A read of an address that matches no register returns 0. This includes 0x18 and 0x1C when `MASK_SHIFT` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | PIN_COUNT | Write data |
| bus_rdata | output | PIN_COUNT | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the read |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output value per pin |
| pin_oe | output | PIN_COUNT | Output enable per pin (1 = drive) |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong bit in the synchronizer or polarity path shows up on a data-in read within three cycles of the pin change. It also moves `irq` one cycle after that when the level mask is set. A cause bit that is set or cleared wrongly shows up on the next cause read and on `irq`, which follows it by one cycle. The bench times a pin edge against a clearing write to probe the collision case. A wrong blink counter shows up as the wrong number of toggles on `pin_out` over a fixed window. A wrong direction or latch bit shows up on `pin_oe` or `pin_out` immediately after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFS_OUT   = 'h00;
  localparam int OFS_DIR   = 'h04;
  localparam int OFS_BLINK = 'h08;
  localparam int OFS_POL   = 'h0C;
  localparam int OFS_DIN   = 'h10;
  localparam int OFS_CAUSE = 'h14;
  localparam int OFS_EMASK = 'h18;
  localparam int OFS_LMASK = 'h1C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_DIR,
    SEL_BLINK,
    SEL_POL,
    SEL_DIN,
    SEL_CAUSE,
    SEL_EMASK,
    SEL_LMASK
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] pol,
  output logic [N-1:0] corr,
  output logic [N-1:0] rise
);
  logic [N-1:0] raw;
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], pin_in[i]};
    end
    assign raw[i] = sh_q[STAGES-1];
  end

  assign corr = raw ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= corr;
  end

  assign rise = corr & ~prev_q;
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign wave = cnt_q[W-1];
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_irq_pkg::*;
#(
  parameter int N          = 32,
  parameter int ADDR_W     = 8,
  parameter int MASK_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  output logic              bus_rvalid,
  input  logic [N-1:0]      din,
  input  logic [N-1:0]      rise,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      blink_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      cause_q,
  output logic [N-1:0]      emask_q,
  output logic [N-1:0]      lmask_q
);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'(OFS_BLINK);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(OFS_EMASK + MASK_SHIFT);
  localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(OFS_LMASK + MASK_SHIFT);

  reg_sel_e sel;
  logic     wr_en;
  logic     rd_en;
  logic [N-1:0] rd_mux;

  always_comb begin
    if      (bus_addr == A_OUT)   sel = SEL_OUT;
    else if (bus_addr == A_DIR)   sel = SEL_DIR;
    else if (bus_addr == A_BLINK) sel = SEL_BLINK;
    else if (bus_addr == A_POL)   sel = SEL_POL;
    else if (bus_addr == A_DIN)   sel = SEL_DIN;
    else if (bus_addr == A_CAUSE) sel = SEL_CAUSE;
    else if (bus_addr == A_EMASK) sel = SEL_EMASK;
    else if (bus_addr == A_LMASK) sel = SEL_LMASK;
    else                          sel = SEL_NONE;
  end

  assign wr_en = bus_valid &&  bus_write;
  assign rd_en = bus_valid && !bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_OUT:   out_q   <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_BLINK: blink_q <= bus_wdata;
        SEL_POL:   pol_q   <= bus_wdata;
        SEL_EMASK: emask_q <= bus_wdata;
        SEL_LMASK: lmask_q <= bus_wdata;
        default:   ;
      endcase
    end
  end

  // Clear-by-zero on write; a new edge in the same cycle re-sets the bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (wr_en && sel == SEL_CAUSE) begin
      cause_q <= (cause_q & bus_wdata) | rise;
    end else begin
      cause_q <= cause_q | rise;
    end
  end

  always_comb begin
    case (sel)
      SEL_OUT:   rd_mux = out_q;
      SEL_DIR:   rd_mux = dir_q;
      SEL_BLINK: rd_mux = blink_q;
      SEL_POL:   rd_mux = pol_q;
      SEL_DIN:   rd_mux = din;
      SEL_CAUSE: rd_mux = cause_q;
      SEL_EMASK: rd_mux = emask_q;
      SEL_LMASK: rd_mux = lmask_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int PIN_COUNT  = 32,
  parameter int ADDR_W     = 8,
  parameter int MASK_SHIFT = 0,
  parameter int BLINK_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PIN_COUNT-1:0] bus_wdata,
  output logic [PIN_COUNT-1:0] bus_rdata,
  output logic                 bus_rvalid,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq
);
  logic [PIN_COUNT-1:0] data_in_w;
  logic [PIN_COUNT-1:0] rise_w;
  logic [PIN_COUNT-1:0] out_w;
  logic [PIN_COUNT-1:0] dir_w;
  logic [PIN_COUNT-1:0] blink_w;
  logic [PIN_COUNT-1:0] pol_w;
  logic [PIN_COUNT-1:0] cause_w;
  logic [PIN_COUNT-1:0] emask_w;
  logic [PIN_COUNT-1:0] lmask_w;
  logic                 wave_w;
  logic                 irq_next;

  gpio_in_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .pol    (pol_w),
    .corr   (data_in_w),
    .rise   (rise_w)
  );

  gpio_blink_gen #(.W(BLINK_W)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .wave  (wave_w)
  );

  gpio_reg_file #(.N(PIN_COUNT), .ADDR_W(ADDR_W), .MASK_SHIFT(MASK_SHIFT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .din        (data_in_w),
    .rise       (rise_w),
    .out_q      (out_w),
    .dir_q      (dir_w),
    .blink_q    (blink_w),
    .pol_q      (pol_w),
    .cause_q    (cause_w),
    .emask_q    (emask_w),
    .lmask_q    (lmask_w)
  );

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_drv
    assign pin_out[i] = blink_w[i] ? wave_w : out_w[i];
    assign pin_oe[i]  = ~dir_w[i];
  end

  assign irq_next = |((data_in_w & lmask_w) | (cause_w & emask_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_valid,
  input logic         bus_write,
  input logic         bus_rvalid,
  input logic [N-1:0] pin_oe,
  input logic         irq,
  input logic [N-1:0] din,
  input logic [N-1:0] cause,
  input logic [N-1:0] emask,
  input logic [N-1:0] lmask,
  input logic [N-1:0] rise
);
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid); // R10

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !bus_rvalid); // R10

  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && bus_write) |-> $stable(pin_oe)); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|((din & lmask) | (cause & emask)))); // R8

  AST_EDGE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((cause & $past(rise)) == $past(rise))); // R7
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(PIN_COUNT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_rvalid (bus_rvalid),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .din        (data_in_w),
  .cause      (cause_w),
  .emask      (emask_w),
  .lmask      (lmask_w),
  .rise       (rise_w)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
  localparam int N  = 8;
  localparam int AW = 8;
  localparam int SH = 32;
  localparam int BW = 4;

  localparam logic [AW-1:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLK = 8'h08, A_POL = 8'h0C;
  localparam logic [AW-1:0] A_DIN = 8'h10, A_CAU = 8'h14;
  localparam logic [AW-1:0] A_EM = 8'h18 + SH, A_LM = 8'h1C + SH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(N), .ADDR_W(AW), .MASK_SHIFT(SH), .BLINK_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    rd(A_DIR, d);  check("R1 dir", {24'b0, d}, 32'hFF);
    rd(A_OUT, d);  check("R1 out", {24'b0, d}, 32'h00);
    rd(A_CAU, d);  check("R1 cause", {24'b0, d}, 32'h00);
    rd(A_EM, d);   check("R1 emask", {24'b0, d}, 32'h00);
    check("R1 oe", {24'b0, pin_oe}, 32'h00);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [N-1:0] d;
    wr(A_OUT, 8'hA5); wr(A_DIR, 8'h0F);
    check("R3 oe", {24'b0, pin_oe}, 32'hF0);
    check("R3 out", {24'b0, pin_out}, 32'hA5);
    rd(A_OUT, d); check("R2 out rb", {24'b0, d}, 32'hA5);
    wr(A_POL, 8'h33); rd(A_POL, d); check("R2 pol rb", {24'b0, d}, 32'h33);
    wr(A_EM, 8'h5A);  rd(A_EM, d);  check("R2 emask rb", {24'b0, d}, 32'h5A);
    wr(A_LM, 8'hC3);  rd(A_LM, d);  check("R2 lmask rb", {24'b0, d}, 32'hC3);
    rd(8'h18, d); check("R11 unshifted emask", {24'b0, d}, 32'h00);
    rd(8'h1C, d); check("R11 unshifted lmask", {24'b0, d}, 32'h00);
    wr(A_DIN, 8'hFF); rd(A_DIN, d); check("R10 din ro", {24'b0, d}, 32'h33);
    wr(A_EM, 8'h00); wr(A_LM, 8'h00); wr(A_POL, 8'h00); wr(A_DIR, 8'hFF); wr(A_OUT, 8'h00);
  endtask

  task automatic t_din();
    logic [N-1:0] d;
    wr(A_POL, 8'h0F);
    @(negedge clk); pin_in = 8'h3C;
    idle(3);
    rd(A_DIN, d); check("R4 din", {24'b0, d}, 32'h33);
  endtask

  task automatic t_edge();
    logic [N-1:0] d;
    @(negedge clk); pin_in = 8'h00;
    wr(A_POL, 8'h00); idle(4);
    wr(A_CAU, 8'h00); rd(A_CAU, d); check("R6 clear all", {24'b0, d}, 32'h00);
    wr(A_EM, 8'h01);
    @(negedge clk); pin_in = 8'h01;
    idle(5);
    rd(A_CAU, d); check("R5 rising", {24'b0, d}, 32'h01);
    check("R8 edge irq", {31'b0, irq}, 32'h1);
    @(negedge clk); pin_in = 8'h03;
    idle(4);
    wr(A_POL, 8'h02); idle(4);
    wr(A_CAU, 8'h01);
    @(negedge clk); pin_in = 8'h01;
    idle(5);
    rd(A_CAU, d); check("R5 falling", {24'b0, d}, 32'h03);
    wr(A_CAU, 8'hFE);
    rd(A_CAU, d); check("R6 partial", {24'b0, d}, 32'h02);
    idle(2);
    check("R8 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collide();
    logic [N-1:0] d;
    wr(A_CAU, 8'h00);
    @(negedge clk); pin_in = 8'h05;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_CAU; bus_wdata = 8'h00;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(A_CAU, d); check("R7 set wins", {24'b0, d}, 32'h04);
    wr(A_CAU, 8'h00);
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    wr(A_EM, 8'h00);
    @(negedge clk); pin_in = 8'h10;
    wr(A_POL, 8'h10); idle(4);
    wr(A_CAU, 8'h00);
    wr(A_LM, 8'h10); idle(3);
    check("R8 level irq", {31'b0, irq}, 32'h0);
    @(negedge clk); pin_in = 8'h00;
    idle(4);
    check("R8 level low", {31'b0, irq}, 32'h1);
    idle(6);
    check("R8 level hold", {31'b0, irq}, 32'h1);
    @(negedge clk); pin_in = 8'h10;
    idle(4);
    check("R8 level gone", {31'b0, irq}, 32'h0);
    wr(A_LM, 8'h00); wr(A_POL, 8'h00);
  endtask

  task automatic t_blink();
    int toggles = 0;
    logic prev;
    wr(A_DIR, 8'h3F); wr(A_OUT, 8'h40); wr(A_BLK, 8'h80);
    @(negedge clk); prev = pin_out[7];
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pin_out[7] != prev) toggles++;
      prev = pin_out[7];
      if (pin_out[6] !== 1'b1) begin
        errors++; $display("FAIL R9 latch pin6: actual %0b expected 1", pin_out[6]);
      end
    end
    checks++;
    check("R9 toggles", toggles, 4);
    wr(A_BLK, 8'h00);
    check("R9 blink off", {24'b0, pin_out}, 32'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_din();
    t_edge();
    t_collide();
    t_level();
    t_blink();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule